// File: doc/BRIEF.md
# Strap-Addressed SMBus Block Register Slave

This block is a serial management slave that holds a nine-byte configuration file for a clock-distribution device. It samples the bus clock and data lines with a fast system clock. It answers one 7-bit address, chosen by two three-level address straps. The host writes a byte run by sending a start index, a byte count and then the data bytes. The host reads a byte run by setting the index, issuing a repeated start, and then clocking out a count byte followed by data bytes until it NACKs.

The register file drives twelve per-output enable bits, a mode-override flag and a two-bit mode select into the surrounding logic. It returns strap-latched mode and frequency values, a revision field, a fixed vendor code and a fixed device identifier as read-only fields. The data line is open-drain. The block drives it only through an active-high pull-low enable.

Top module: `smb_cfg_slave`

## Requirements
- R1: Each strap uses code 00 for low, 01 for mid and 10 for high; code 11 is treated as mid. The address byte with its low bit cleared is, for (hi strap, lo strap): low,low=D8; low,mid=DA; low,high=DE; mid,low=C2; mid,mid=C4; mid,high=C6; high,low=CA; high,mid=CC; high,high=CE. A non-matching address is NACKed, and every byte after it is ignored until the next start.
- R2: A block write (address+W, index N, count X, data) ACKs every byte and stores data byte k at index N+k for k < X.
- R3: Data bytes beyond the count are ACKed and discarded. A count of 0 writes nothing.
- R4: A block read (address+W, index N, repeated start, address+R) returns a count byte equal to byte 7 bits 4:0, then bytes N, N+1, … while the host ACKs. After the host NACKs, the slave releases the data line.
- R5: After reset, byte 1 = FF, byte 2 bits 3:0 = F, byte 0 bits 3:1 = 0 and byte 7 = 08.
- R6: Byte 0 bits 7:6 read the mode strap and bit 0 reads the frequency strap. Byte 5 reads {revision input, 0001}. Byte 6 reads FB. Writes leave all of these unchanged.
- R7: Bytes 3, 4 and 8, byte 0 bits 5:4, byte 2 bits 7:4 and byte 7 bits 7:5 read 0, whatever value is written.
- R8: Reads at an index above 8 return 00. Writes at an index above 8 are discarded, and both are ACKed.
- R9: The slave changes its pull-low enable only while SCL is low.
- R10: A stop or a new start at any point returns the slave to idle with the line released. Bytes completed before it stay applied, and a partial byte is dropped.
- R11: out_en[7:0] equals byte 1, out_en[11:8] equals byte 2 bits 3:0, mode_override equals byte 0 bit 3 and mode_sel equals byte 0 bits 2:1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock level |
| sda_in | input | 1 | Bus data level |
| sda_pull | output | 1 | 1 pulls the data line low |
| addr_strap_hi | input | 2 | Upper address strap code |
| addr_strap_lo | input | 2 | Lower address strap code |
| mode_strap | input | 2 | Latched mode value, read back in byte 0 bits 7:6 |
| freq_strap | input | 1 | Latched frequency select, read back in byte 0 bit 0 |
| rev_id | input | 4 | Revision value, read back in byte 5 bits 7:4 |
| out_en | output | 12 | Per-output enable bits |
| mode_override | output | 1 | Software mode override flag |
| mode_sel | output | 2 | Software mode select |

## Verification
The address decoder is tried at all nine strap pairs plus the 11 code. A wrong address followed by a full write shows whether a NACKed transfer leaks into the registers. Block writes with random index, count and extra bytes, each followed by a full readback, separate the count limit, the index increment and the per-bit write masks. Directed runs at indices past 8, with a zero count, with aborts by stop and by repeated start mid-byte, and with a changed count register show, respectively, out-of-range handling, count gating, partial-byte dropping and the value of the count byte.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;

  localparam int REG_COUNT = 9;
  localparam int OUT_CNT   = 12;
  localparam int LO_OUTS   = 8;
  localparam int CNT_W     = 5;
  localparam int BYTE_BITS = 8;
  localparam int BIT_W     = $clog2(BYTE_BITS + 1);

  localparam logic [7:0] RW0_RESET = 8'h00;
  localparam logic [7:0] RW1_RESET = 8'hFF;
  localparam logic [7:0] RW2_RESET = 8'h0F;
  localparam logic [7:0] RW7_RESET = 8'h08;

  typedef enum logic [2:0] {
    LK_IDLE, LK_RECV, LK_SACK, LK_SEND, LK_HACK
  } link_state_e;

  typedef enum logic [1:0] {
    PH_ADDR, PH_INDEX, PH_COUNT, PH_DATA
  } phase_e;

  // strap code to level 0 (low), 1 (mid), 2 (high); code 11 counts as mid
  function automatic logic [1:0] strap_level(input logic [1:0] code);
    logic [1:0] lvl;
    case (code)
      2'b00:   lvl = 2'd0;
      2'b10:   lvl = 2'd2;
      default: lvl = 2'd1;
    endcase
    return lvl;
  endfunction

  // 7-bit bus address selected by the two straps
  function automatic logic [6:0] strap_address(input logic [1:0] hi_code,
                                                input logic [1:0] lo_code);
    logic [7:0] b;
    case ({strap_level(hi_code), strap_level(lo_code)})
      4'b0000: b = 8'hD8;
      4'b0001: b = 8'hDA;
      4'b0010: b = 8'hDE;
      4'b0100: b = 8'hC2;
      4'b0101: b = 8'hC4;
      4'b0110: b = 8'hC6;
      4'b1000: b = 8'hCA;
      4'b1001: b = 8'hCC;
      4'b1010: b = 8'hCE;
      default: b = 8'hC4;
    endcase
    return b[7:1];
  endfunction

  // bits that software may change at each index
  function automatic logic [7:0] write_mask(input logic [7:0] idx);
    logic [7:0] m;
    case (idx)
      8'd0:    m = 8'h0E;
      8'd1:    m = 8'hFF;
      8'd2:    m = 8'h0F;
      8'd7:    m = 8'h1F;
      default: m = 8'h00;
    endcase
    return m;
  endfunction

  function automatic logic [7:0] count_byte(input logic [CNT_W-1:0] cnt);
    return {{(8-CNT_W){1'b0}}, cnt};
  endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_raw,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
      last_q  <= 1'b1;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], d_raw};
      last_q  <= chain_q[STAGES-1];
    end
  end

  assign level = chain_q[STAGES-1];
  assign rise  = level & ~last_q;
  assign fall  = ~level & last_q;
endmodule

// File: rtl/smb_cfg_regs.sv
module smb_cfg_regs
  import smb_cfg_pkg::*;
#(
  parameter logic [7:0] DEVICE_ID = 8'hFB,
  parameter logic [3:0] VENDOR_ID = 4'h1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_stb,
  input  logic [7:0]         wr_idx,
  input  logic [7:0]         wr_data,
  input  logic [7:0]         rd_idx,
  output logic [7:0]         rd_data,
  input  logic [1:0]         mode_strap,
  input  logic               freq_strap,
  input  logic [3:0]         rev_id,
  output logic [OUT_CNT-1:0] out_en,
  output logic               mode_override,
  output logic [1:0]         mode_sel,
  output logic [CNT_W-1:0]   count_val
);
  logic [7:0] rw0_q, rw1_q, rw2_q, rw7_q;
  logic [7:0] masked;

  assign masked = wr_data & write_mask(wr_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rw0_q <= RW0_RESET;
      rw1_q <= RW1_RESET;
      rw2_q <= RW2_RESET;
      rw7_q <= RW7_RESET;
    end else if (wr_stb) begin
      case (wr_idx)
        8'd0:    rw0_q <= masked;
        8'd1:    rw1_q <= masked;
        8'd2:    rw2_q <= masked;
        8'd7:    rw7_q <= masked;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (rd_idx)
      8'd0:    rd_data = rw0_q | {mode_strap, 5'b00000, freq_strap};
      8'd1:    rd_data = rw1_q;
      8'd2:    rd_data = rw2_q;
      8'd5:    rd_data = {rev_id, VENDOR_ID};
      8'd6:    rd_data = DEVICE_ID;
      8'd7:    rd_data = rw7_q;
      default: rd_data = 8'h00;
    endcase
  end

  assign out_en        = {rw2_q[OUT_CNT-LO_OUTS-1:0], rw1_q[LO_OUTS-1:0]};
  assign mode_override = rw0_q[3];
  assign mode_sel      = rw0_q[2:1];
  assign count_val     = rw7_q[CNT_W-1:0];
endmodule

// File: rtl/smb_link_fsm.sv
module smb_link_fsm
  import smb_cfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             sda_lvl,
  input  logic             start_evt,
  input  logic             stop_evt,
  input  logic [6:0]       own_addr,
  input  logic [7:0]       rd_data,
  input  logic [CNT_W-1:0] count_val,
  output logic             sda_pull,
  output logic             wr_stb,
  output logic [7:0]       wr_idx,
  output logic [7:0]       wr_data,
  output logic [7:0]       rd_idx,
  output logic             link_idle
);
  link_state_e      st_q;
  phase_e           ph_q;
  logic [BIT_W-1:0] bit_q;
  logic [7:0]       rx_q, tx_q, idx_q, left_q;
  logic             rd_dir_q, hack_q;
  logic             wr_stb_q;
  logic [7:0]       wr_idx_q, wr_data_q;
  logic             byte_end, addr_hit;

  assign byte_end = scl_fall && (bit_q == BIT_W'(BYTE_BITS));
  assign addr_hit = (rx_q[7:1] == own_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= LK_IDLE;
      ph_q      <= PH_ADDR;
      bit_q     <= '0;
      rx_q      <= '0;
      tx_q      <= '0;
      idx_q     <= '0;
      left_q    <= '0;
      rd_dir_q  <= 1'b0;
      hack_q    <= 1'b0;
      wr_stb_q  <= 1'b0;
      wr_idx_q  <= '0;
      wr_data_q <= '0;
    end else begin
      wr_stb_q <= 1'b0;
      if (stop_evt) begin
        st_q <= LK_IDLE;
      end else if (start_evt) begin
        st_q  <= LK_RECV;
        ph_q  <= PH_ADDR;
        bit_q <= '0;
      end else begin
        case (st_q)
          LK_RECV: begin
            if (scl_rise) begin
              rx_q  <= {rx_q[6:0], sda_lvl};
              bit_q <= bit_q + 1'b1;
            end else if (byte_end) begin
              case (ph_q)
                PH_ADDR: begin
                  if (addr_hit) begin
                    st_q     <= LK_SACK;
                    rd_dir_q <= rx_q[0];
                  end else begin
                    st_q <= LK_IDLE;
                  end
                end
                PH_INDEX: begin
                  idx_q <= rx_q;
                  ph_q  <= PH_COUNT;
                  st_q  <= LK_SACK;
                end
                PH_COUNT: begin
                  left_q <= rx_q;
                  ph_q   <= PH_DATA;
                  st_q   <= LK_SACK;
                end
                default: begin
                  st_q <= LK_SACK;
                  if (left_q != 8'd0) begin
                    wr_stb_q  <= 1'b1;
                    wr_idx_q  <= idx_q;
                    wr_data_q <= rx_q;
                    idx_q     <= idx_q + 8'd1;
                    left_q    <= left_q - 8'd1;
                  end
                end
              endcase
            end
          end
          LK_SACK: begin
            if (scl_fall) begin
              bit_q <= '0;
              if (ph_q == PH_ADDR && rd_dir_q) begin
                st_q <= LK_SEND;
                tx_q <= count_byte(count_val);
              end else begin
                st_q <= LK_RECV;
                if (ph_q == PH_ADDR) ph_q <= PH_INDEX;
              end
            end
          end
          LK_SEND: begin
            if (scl_fall) begin
              if (bit_q == BIT_W'(BYTE_BITS - 1)) begin
                st_q <= LK_HACK;
              end else begin
                tx_q  <= {tx_q[6:0], 1'b0};
                bit_q <= bit_q + 1'b1;
              end
            end
          end
          LK_HACK: begin
            if (scl_rise) begin
              hack_q <= ~sda_lvl;
            end else if (scl_fall) begin
              if (hack_q) begin
                st_q  <= LK_SEND;
                tx_q  <= rd_data;
                idx_q <= idx_q + 8'd1;
                bit_q <= '0;
              end else begin
                st_q <= LK_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_pull  = (st_q == LK_SACK) || (st_q == LK_SEND && !tx_q[7]);
  assign wr_stb    = wr_stb_q;
  assign wr_idx    = wr_idx_q;
  assign wr_data   = wr_data_q;
  assign rd_idx    = idx_q;
  assign link_idle = (st_q == LK_IDLE);
endmodule

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave
  import smb_cfg_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] DEVICE_ID   = 8'hFB,
  parameter logic [3:0] VENDOR_ID   = 4'h1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_in,
  input  logic               sda_in,
  output logic               sda_pull,
  input  logic [1:0]         addr_strap_hi,
  input  logic [1:0]         addr_strap_lo,
  input  logic [1:0]         mode_strap,
  input  logic               freq_strap,
  input  logic [3:0]         rev_id,
  output logic [OUT_CNT-1:0] out_en,
  output logic               mode_override,
  output logic [1:0]         mode_sel
);
  // named internal events, also watched by the bound checker
  logic             scl_s, scl_rise, scl_fall;
  logic             sda_s, sda_rise, sda_fall;
  logic             start_evt, stop_evt;
  logic [6:0]       own_addr;
  logic             wr_stb;
  logic [7:0]       wr_idx, wr_data, rd_idx, rd_data;
  logic [CNT_W-1:0] count_val;
  logic             link_idle;

  smb_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk(clk), .rst_n(rst_n), .d_raw(scl_in),
    .level(scl_s), .rise(scl_rise), .fall(scl_fall)
  );

  smb_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk(clk), .rst_n(rst_n), .d_raw(sda_in),
    .level(sda_s), .rise(sda_rise), .fall(sda_fall)
  );

  assign start_evt = sda_fall & scl_s;
  assign stop_evt  = sda_rise & scl_s;
  assign own_addr  = strap_address(addr_strap_hi, addr_strap_lo);

  smb_link_fsm u_link (
    .clk(clk), .rst_n(rst_n),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_lvl(sda_s),
    .start_evt(start_evt), .stop_evt(stop_evt),
    .own_addr(own_addr), .rd_data(rd_data), .count_val(count_val),
    .sda_pull(sda_pull), .wr_stb(wr_stb), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .link_idle(link_idle)
  );

  smb_cfg_regs #(.DEVICE_ID(DEVICE_ID), .VENDOR_ID(VENDOR_ID)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_stb(wr_stb), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data),
    .mode_strap(mode_strap), .freq_strap(freq_strap), .rev_id(rev_id),
    .out_en(out_en), .mode_override(mode_override), .mode_sel(mode_sel),
    .count_val(count_val)
  );
endmodule

// File: rtl/smb_cfg_checks.sv
module smb_cfg_checks
  import smb_cfg_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               scl_s,
  input logic               sda_pull,
  input logic               start_evt,
  input logic               stop_evt,
  input logic               wr_stb,
  input logic               link_idle,
  input logic [OUT_CNT-1:0] out_en,
  input logic               mode_override,
  input logic [1:0]         mode_sel,
  input logic [CNT_W-1:0]   count_val
);
  p_pull_steady_scl_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s)) |-> $stable(sda_pull));

  p_stop_releases_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (link_idle && !sda_pull));

  p_start_releases_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (!link_idle && !sda_pull));

  p_en_needs_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(out_en) |-> $past(wr_stb));

  p_ctl_needs_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({mode_override, mode_sel, count_val}) |-> $past(wr_stb));

  p_single_write_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);
endmodule

bind smb_cfg_slave smb_cfg_checks u_checks (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_pull(sda_pull),
  .start_evt(start_evt), .stop_evt(stop_evt), .wr_stb(wr_stb),
  .link_idle(link_idle), .out_en(out_en), .mode_override(mode_override),
  .mode_sel(mode_sel), .count_val(count_val)
);

// File: tb/tb_smb_cfg_slave.sv
module tb_smb_cfg_slave;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_h = 1'b1;
  logic sda_pull;
  wire  sda = sda_h & ~sda_pull;
  logic [1:0]  strap_hi = 2'b00, strap_lo = 2'b00, mode_strap = 2'b10;
  logic        freq_strap = 1'b1;
  logic [3:0]  rev_id = 4'h3;
  logic [11:0] out_en;
  logic        mode_override;
  logic [1:0]  mode_sel;

  int checks = 0, fails = 0, hi_toggles = 0;
  logic [7:0] wbuf[16];
  logic [7:0] rbuf[16];
  logic [2:0]  m_ctl = 3'b000;
  logic [11:0] m_en = 12'hFFF;
  logic [4:0]  m_cnt = 5'd8;

  smb_cfg_slave dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda), .sda_pull(sda_pull),
    .addr_strap_hi(strap_hi), .addr_strap_lo(strap_lo), .mode_strap(mode_strap),
    .freq_strap(freq_strap), .rev_id(rev_id), .out_en(out_en),
    .mode_override(mode_override), .mode_sel(mode_sel)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // R9 monitor: pull enable must not move while SCL stays high
  logic scl_prev = 1'b1, pull_prev = 1'b0;
  always @(posedge clk) begin
    #2;
    if (rst_n && scl && scl_prev && (sda_pull != pull_prev)) hi_toggles++;
    scl_prev = scl;
    pull_prev = sda_pull;
  end

  function automatic logic [7:0] exp_addr(input logic [1:0] hi, input logic [1:0] lo);
    int h = (hi == 2'b00) ? 0 : (hi == 2'b10) ? 2 : 1;
    int l = (lo == 2'b00) ? 0 : (lo == 2'b10) ? 2 : 1;
    logic [7:0] base = (h == 0) ? 8'hD8 : (h == 1) ? 8'hC2 : 8'hCA;
    if (h == 0 && l == 2) return base + 8'd6;
    return base + 8'(2 * l);
  endfunction

  function automatic logic [7:0] exp_byte(input int idx);
    case (idx)
      0: return {mode_strap, 2'b00, m_ctl, freq_strap};
      1: return m_en[7:0];
      2: return {4'h0, m_en[11:8]};
      5: return {rev_id, 4'b0001};
      6: return 8'hFB;
      7: return {3'b000, m_cnt};
      default: return 8'h00;
    endcase
  endfunction

  function automatic void model_write(input int idx, input logic [7:0] d);
    case (idx)
      0: m_ctl = d[3:1];
      1: m_en[7:0] = d;
      2: m_en[11:8] = d[3:0];
      7: m_cnt = d[4:0];
      default: ;
    endcase
  endfunction

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_h = 1'b1; w(Q); scl = 1'b1; w(Q); sda_h = 1'b0; w(Q); scl = 1'b0; w(Q);
  endtask

  task automatic bus_stop();
    sda_h = 1'b0; w(Q); scl = 1'b1; w(Q); sda_h = 1'b1; w(2*Q);
  endtask

  task automatic send_bit(input logic b);
    sda_h = b; w(Q); scl = 1'b1; w(2*Q); scl = 1'b0; w(Q);
  endtask

  task automatic recv_bit(output logic b);
    sda_h = 1'b1; w(Q); scl = 1'b1; w(Q); b = sda; w(Q); scl = 1'b0; w(Q);
  endtask

  task automatic send_byte(input logic [7:0] d, output bit acked);
    logic a;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(a);
    acked = !a;
  endtask

  task automatic recv_byte(output logic [7:0] d, input bit give_ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin recv_bit(b); d[i] = b; end
    send_bit(!give_ack);
  endtask

  task automatic do_write(input logic [7:0] dev, input logic [7:0] idx, input logic [7:0] cnt,
                          input int n, output int acks);
    bit a;
    acks = 0;
    bus_start();
    send_byte({dev[7:1], 1'b0}, a); acks += int'(a);
    send_byte(idx, a); acks += int'(a);
    send_byte(cnt, a); acks += int'(a);
    for (int k = 0; k < n; k++) begin send_byte(wbuf[k], a); acks += int'(a); end
    bus_stop();
  endtask

  task automatic do_read(input logic [7:0] dev, input logic [7:0] idx, input int n,
                         output logic [7:0] cb, output int acks);
    bit a;
    acks = 0;
    bus_start();
    send_byte({dev[7:1], 1'b0}, a); acks += int'(a);
    send_byte(idx, a); acks += int'(a);
    sda_h = 1'b1; w(Q); scl = 1'b1; w(Q); sda_h = 1'b0; w(Q); scl = 1'b0; w(Q);
    send_byte({dev[7:1], 1'b1}, a); acks += int'(a);
    recv_byte(cb, 1'b1);
    for (int k = 0; k < n; k++) recv_byte(rbuf[k], k < n - 1);
    chk(sda_pull == 1'b0, "R4 line released after host NACK", 32'(sda_pull), 0);
    bus_stop();
  endtask

  task automatic apply_model(input int idx, input int cnt, input int n);
    for (int k = 0; k < n; k++) if (k < cnt) model_write(idx + k, wbuf[k]);
  endtask

  task automatic read_all(input string tag);
    logic [7:0] cb;
    int acks;
    do_read(exp_addr(strap_hi, strap_lo), 8'd0, 9, cb, acks);
    chk(acks == 3, {tag, " R4 read acks"}, acks, 3);
    chk(cb == {3'b000, m_cnt}, {tag, " R4 count byte"}, cb, {3'b000, m_cnt});
    for (int k = 0; k < 9; k++)
      chk(rbuf[k] == exp_byte(k), $sformatf("%s R2/R6/R7 byte %0d", tag, k), rbuf[k], exp_byte(k));
  endtask

  task automatic check_outputs(input string tag);
    chk(out_en == m_en, {tag, " R11 out_en"}, out_en, m_en);
    chk({mode_override, mode_sel} == m_ctl, {tag, " R11 mode controls"}, {mode_override, mode_sel}, m_ctl);
  endtask

  bit done = 1'b0;
  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int acks;
    logic [7:0] cb;
    void'($urandom(32'd4242));
    w(5); rst_n = 1'b1; w(5);

    // R5 reset state
    chk(out_en == 12'hFFF, "R5 reset out_en", out_en, 12'hFFF);
    chk({mode_override, mode_sel} == 3'b000, "R5 reset mode controls", {mode_override, mode_sel}, 0);
    chk(sda_pull == 1'b0, "R5 reset line released", 32'(sda_pull), 0);
    read_all("reset R5");

    // R1 all strap pairs, plus code 11
    for (int s = 0; s < 10; s++) begin
      strap_hi = (s == 9) ? 2'b11 : 2'((s / 3) == 2 ? 2'b10 : (s / 3));
      strap_lo = (s == 9) ? 2'b11 : 2'((s % 3) == 2 ? 2'b10 : (s % 3));
      w(4);
      wbuf[0] = 8'(s * 17 + 3);
      do_write(exp_addr(strap_hi, strap_lo), 8'd1, 8'd1, 1, acks);
      chk(acks == 4, $sformatf("R1 address %0h acked", exp_addr(strap_hi, strap_lo)), acks, 4);
      apply_model(1, 1, 1);
      check_outputs("R1 write");
      wbuf[0] = 8'h00;
      do_write(exp_addr(strap_hi, strap_lo) ^ 8'h10, 8'd1, 8'd1, 1, acks);
      chk(acks == 0, "R1 wrong address NACKed", acks, 0);
      check_outputs("R1 ignored after NACK");
    end
    strap_hi = 2'b10; strap_lo = 2'b01; w(4);

    // R8 index above 8
    do_read(exp_addr(strap_hi, strap_lo), 8'd9, 2, cb, acks);
    chk(rbuf[0] == 8'h00 && rbuf[1] == 8'h00, "R8 read above 8", {rbuf[0], rbuf[1]}, 0);
    wbuf[0] = 8'h55; wbuf[1] = 8'hAA;
    do_write(exp_addr(strap_hi, strap_lo), 8'd10, 8'd2, 2, acks);
    chk(acks == 5, "R8 write above 8 acked", acks, 5);
    read_all("R8 after");

    // R3 count limits
    wbuf[0] = 8'h12; wbuf[1] = 8'h34;
    do_write(exp_addr(strap_hi, strap_lo), 8'd1, 8'd0, 2, acks);
    chk(acks == 5, "R3 zero count acks", acks, 5);
    check_outputs("R3 zero count");
    wbuf[0] = 8'h3C; wbuf[1] = 8'h0A; wbuf[2] = 8'h0B;
    do_write(exp_addr(strap_hi, strap_lo), 8'd1, 8'd1, 3, acks);
    chk(acks == 6, "R3 extra bytes acked", acks, 6);
    apply_model(1, 1, 3);
    check_outputs("R3 extra bytes dropped");

    // R6 R7 write all ones everywhere
    for (int k = 0; k < 9; k++) wbuf[k] = 8'hFF;
    do_write(exp_addr(strap_hi, strap_lo), 8'd0, 8'd9, 9, acks);
    chk(acks == 12, "R2 nine byte write acks", acks, 12);
    apply_model(0, 9, 9);
    read_all("R6 R7 ones");
    check_outputs("R6 ones");

    // R4 count register value drives count byte
    wbuf[0] = 8'hE3;
    do_write(exp_addr(strap_hi, strap_lo), 8'd7, 8'd1, 1, acks);
    apply_model(7, 1, 1);
    do_read(exp_addr(strap_hi, strap_lo), 8'd5, 2, cb, acks);
    chk(cb == 8'h03, "R4 count byte follows register", cb, 8'h03);
    chk(rbuf[0] == exp_byte(5) && rbuf[1] == 8'hFB, "R4 R6 data from index 5", {rbuf[0], rbuf[1]}, {exp_byte(5), 8'hFB});

    // R10 stop mid byte
    wbuf[0] = 8'h5A;
    bus_start();
    begin
      bit a;
      send_byte({exp_addr(strap_hi, strap_lo)}, a);
      send_byte(8'd1, a); send_byte(8'd2, a); send_byte(8'h5A, a);
      for (int i = 0; i < 4; i++) send_bit(1'b0);
      bus_stop();
    end
    apply_model(1, 1, 1);
    check_outputs("R10 stop keeps completed byte");
    // R10 repeated start mid byte
    bus_start();
    begin
      bit a;
      send_byte(exp_addr(strap_hi, strap_lo), a);
      send_byte(8'd2, a); send_byte(8'd2, a); send_byte(8'h05, a);
      for (int i = 0; i < 3; i++) send_bit(1'b0);
      sda_h = 1'b1; w(Q); scl = 1'b1; w(Q); sda_h = 1'b0; w(Q); scl = 1'b0; w(Q);
      send_byte(exp_addr(strap_hi, strap_lo), a);
      chk(a == 1'b1, "R10 address after restart acked", 32'(a), 1);
      send_byte(8'd7, a); send_byte(8'd1, a); send_byte(8'h04, a);
      bus_stop();
    end
    model_write(2, 8'h05); model_write(7, 8'h04);
    read_all("R10 restart");
    check_outputs("R10 restart");

    // random block writes with full readback
    for (int it = 0; it < 22; it++) begin
      int idx, cnt, n;
      strap_hi = 2'($urandom_range(0, 3));
      strap_lo = 2'($urandom_range(0, 3));
      mode_strap = 2'($urandom_range(0, 2));
      idx = $urandom_range(0, 10);
      cnt = $urandom_range(0, 4);
      n = cnt + $urandom_range(0, 1);
      for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
      if (idx + cnt > 7 && idx <= 7) wbuf[7 - idx] = 8'($urandom_range(0, 15)) | 8'h03;
      w(4);
      do_write(exp_addr(strap_hi, strap_lo), 8'(idx), 8'(cnt), n, acks);
      chk(acks == 3 + n, "R2 random write acks", acks, 3 + n);
      apply_model(idx, cnt, n);
      read_all($sformatf("R2 random %0d", it));
      check_outputs("R11 random");
    end

    chk(hi_toggles == 0, "R9 pull moved while SCL high", hi_toggles, 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule